// File: doc/BRIEF.md
# UART FIFO Control with Receive Threshold

This block holds the character buffers of a serial port: one 16-entry receive queue and one 16-entry transmit queue. A single 8-bit control write governs both. It turns the two queues on or off, empties either one on demand, and picks how full the receive queue must be before an interrupt request is raised. The serial shifters sit outside the block. They push received characters into the receive queue and pop characters to send from the transmit queue. The processor side does the opposite.

A control write takes effect at the clock edge on which it is strobed. Any flush caused by that write empties the affected queue at that same edge. The flush bits are pulses and are never stored. The receive interrupt request is a level. It stays high as long as the receive occupancy is at or above the chosen threshold.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the queues are disabled and both are empty, with count 0, full flags low, read data 0, and the interrupt request low. The threshold is 1 character.
- R2: Bit 0 of the control word is the enable. While the enable is 0, pushes and pops on both queues are ignored and both queues stay empty.
- R3: Any control write whose bit 0 differs from the current enable empties both queues at that clock edge, whether it turns the enable on or off.
- R4: A write with bit 0 and bit 1 both set empties the receive queue and leaves the transmit queue intact. The bit is not stored, so a later write with bit 1 clear flushes nothing.
- R5: A write with bit 0 and bit 2 both set empties the transmit queue and leaves the receive queue intact. The bit is not stored either.
- R6: Bits 7:6 of an enabling write select the receive threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 characters. The interrupt request is high exactly while the receive count is greater than or equal to the threshold.
- R7: Bits 5:3 of the control word have no effect.
- R8: Each queue returns data in the order it was pushed and holds 16 entries. The full flag is high at 16 entries. A push into a full queue is dropped. When push and pop arrive together, a pop is taken only if the queue is not empty and a push only if it is not full, both judged before that edge.
- R9: A pop from an empty queue leaves the read data, the count and the flags unchanged.
- R10: When a flush and a push or pop hit the same queue in the same cycle, the flush wins and the queue ends empty with the read data unchanged.
- R11: The receive count reports the receive occupancy, from 0 to 16. The read data of a queue is registered and changes on the clock edge of an accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word value |
| rx_push | input | 1 | Push one character into the receive queue |
| rx_pdata | input | 8 | Character to push into the receive queue |
| rx_pop | input | 1 | Pop one character from the receive queue |
| rx_rdata | output | 8 | Last character popped from the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_count | output | 5 | Receive queue occupancy |
| rx_irq | output | 1 | Receive threshold interrupt request |
| tx_push | input | 1 | Push one character into the transmit queue |
| tx_pdata | input | 8 | Character to push into the transmit queue |
| tx_pop | input | 1 | Pop one character from the transmit queue |
| tx_rdata | output | 8 | Last character popped from the transmit queue |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |

## Verification
The queues are driven in three patterns. Short push-then-pop bursts separate ordering faults from pointer faults. A 17-push overfill of the transmit queue tells a dropped push from a pointer wrap. Pops on an empty queue show whether read data moves when it should hold. The control word is tried with all four threshold codes, walked one character at a time across each boundary, and with the reserved bits set. Flush writes are issued with one queue holding data, so a flush that hits the wrong queue shows up, and together with same-cycle pushes and pops to test precedence. Enable toggles are issued with data present, so the flush on either edge can be seen.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

    localparam int UFC_DATA_W = 8;
    localparam int UFC_DEPTH  = 16;

    typedef enum logic [1:0] {
        TRIG_1  = 2'b00,
        TRIG_4  = 2'b01,
        TRIG_8  = 2'b10,
        TRIG_14 = 2'b11
    } trig_sel_e;

    // Control word layout, MSB first.
    typedef struct packed {
        logic [1:0] trig;
        logic [2:0] unused;
        logic       tx_clr;
        logic       rx_clr;
        logic       enable;
    } ctrl_word_t;

    typedef struct packed {
        logic push;
        logic pop;
        logic flush;
    } fifo_op_t;

    function automatic int trig_depth(trig_sel_e sel);
        case (sel)
            TRIG_1:  return 1;
            TRIG_4:  return 4;
            TRIG_8:  return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/ufc_fifo.sv
module ufc_fifo
    import ufc_pkg::*;
#(
    parameter int DATA_W = UFC_DATA_W,
    parameter int DEPTH  = UFC_DEPTH,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  fifo_op_t          op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              full
);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  occ;
    logic [DATA_W-1:0] rdata_q;
    logic              take_push, take_pop;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    assign take_push = op.push && !op.flush && (occ != FULL_CNT);
    assign take_pop  = op.pop  && !op.flush && (occ != '0);

    always_ff @(posedge clk) begin
        if (take_push) begin
            store[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            occ     <= '0;
            rdata_q <= '0;
        end else if (op.flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (take_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (take_pop) begin
                rd_ptr  <= bump(rd_ptr);
                rdata_q <= store[rd_ptr];
            end
            case ({take_push, take_pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    assign rdata = rdata_q;
    assign count = occ;
    assign empty = (occ == '0);
    assign full  = (occ == FULL_CNT);

endmodule

// File: rtl/ufc_ctrl.sv
module ufc_ctrl
    import ufc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  logic [7:0] wdata,
    output logic      enabled,
    output trig_sel_e trig,
    output logic      rx_flush,
    output logic      tx_flush
);
    ctrl_word_t word;
    logic       en_q;
    trig_sel_e  trig_q;
    logic       en_flip;
    logic       upper_ok;

    assign word     = ctrl_word_t'(wdata);
    assign en_flip  = we && (word.enable != en_q);
    assign upper_ok = we && word.enable;

    assign rx_flush = en_flip || (upper_ok && word.rx_clr);
    assign tx_flush = en_flip || (upper_ok && word.tx_clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            trig_q <= TRIG_1;
        end else if (we) begin
            en_q <= word.enable;
            if (word.enable) begin
                trig_q <= trig_sel_e'(word.trig);
            end
        end
    end

    assign enabled = en_q;
    assign trig    = trig_q;

endmodule

// File: rtl/ufc_trigger.sv
module ufc_trigger
    import ufc_pkg::*;
#(
    parameter int CNT_W = $clog2(UFC_DEPTH + 1)
) (
    input  logic [CNT_W-1:0] count,
    input  trig_sel_e        trig,
    output logic             irq
);
    logic [CNT_W-1:0] level;

    assign level = CNT_W'(trig_depth(trig));
    assign irq   = (count >= level);

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import ufc_pkg::*;
#(
    parameter int DATA_W = UFC_DATA_W,
    parameter int DEPTH  = UFC_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_pdata,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    output logic              rx_empty,
    output logic              rx_full,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_irq,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_pdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_rdata,
    output logic              tx_empty,
    output logic              tx_full
);
    logic      enabled;
    trig_sel_e trig;
    logic      rx_flush, tx_flush;
    fifo_op_t  rx_op, tx_op;
    logic [CNT_W-1:0] tx_count_unused;

    ufc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .enabled  (enabled),
        .trig     (trig),
        .rx_flush (rx_flush),
        .tx_flush (tx_flush)
    );

    assign rx_op = '{push: rx_push && enabled, pop: rx_pop && enabled, flush: rx_flush};
    assign tx_op = '{push: tx_push && enabled, pop: tx_pop && enabled, flush: tx_flush};

    ufc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst   (rst),
        .op    (rx_op),
        .wdata (rx_pdata),
        .rdata (rx_rdata),
        .count (rx_count),
        .empty (rx_empty),
        .full  (rx_full)
    );

    ufc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst   (rst),
        .op    (tx_op),
        .wdata (tx_pdata),
        .rdata (tx_rdata),
        .count (tx_count_unused),
        .empty (tx_empty),
        .full  (tx_full)
    );

    ufc_trigger #(.CNT_W(CNT_W)) u_trigger (
        .count (rx_count),
        .trig  (trig),
        .irq   (rx_irq)
    );

endmodule

// File: rtl/ufc_checker.sv
module ufc_checker
    import ufc_pkg::*;
#(
    parameter int DATA_W = UFC_DATA_W,
    parameter int DEPTH  = UFC_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [7:0]        cfg_wdata,
    input logic              rx_push,
    input logic              rx_pop,
    input logic [DATA_W-1:0] rx_rdata,
    input logic              rx_empty,
    input logic              rx_full,
    input logic [CNT_W-1:0]  rx_count,
    input logic              rx_irq,
    input logic              tx_empty,
    input logic              tx_full
);
    logic       sh_en;
    logic [1:0] sh_trig;
    int         sh_level;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_en   <= 1'b0;
            sh_trig <= 2'b00;
        end else if (cfg_we) begin
            sh_en <= cfg_wdata[0];
            if (cfg_wdata[0]) sh_trig <= cfg_wdata[7:6];
        end
    end

    always_comb begin
        case (sh_trig)
            2'b00:   sh_level = 1;
            2'b01:   sh_level = 4;
            2'b10:   sh_level = 8;
            default: sh_level = 14;
        endcase
    end

    p_disabled_empty_r2: assert property (@(posedge clk) disable iff (rst)
        !sh_en |-> (rx_empty && tx_empty));

    p_toggle_flush_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_wdata[0] != sh_en)) |=> (rx_empty && tx_empty));

    p_rx_flush_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[0] && cfg_wdata[1]) |=> rx_empty);

    p_irq_level_r6: assert property (@(posedge clk) disable iff (rst)
        rx_irq == (int'(rx_count) >= sh_level));

    p_full_flags_r8: assert property (@(posedge clk) disable iff (rst)
        !(rx_full && rx_empty) && !(tx_full && tx_empty));

    p_pop_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && rx_empty) |=> $stable(rx_rdata));

    p_flush_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[0] && cfg_wdata[1] && rx_push) |=> (rx_count == '0));

    p_count_bound_r11: assert property (@(posedge clk) disable iff (rst)
        (int'(rx_count) <= DEPTH) && (rx_full == (int'(rx_count) == DEPTH)));

endmodule

bind uart_fifo_ctl ufc_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ufc_checker (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .rx_push   (rx_push),
    .rx_pop    (rx_pop),
    .rx_rdata  (rx_rdata),
    .rx_empty  (rx_empty),
    .rx_full   (rx_full),
    .rx_count  (rx_count),
    .rx_irq    (rx_irq),
    .tx_empty  (tx_empty),
    .tx_full   (tx_full)
);

// File: tb/uart_fifo_ctl_bench.sv
`timescale 1ns/1ps
module uart_fifo_ctl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0] rx_pdata = '0, tx_pdata = '0;
    logic [7:0] rx_rdata, tx_rdata;
    logic       rx_empty, rx_full, tx_empty, tx_full, rx_irq;
    logic [4:0] rx_count;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // scoreboard model
    logic [7:0] rx_q[$];
    logic [7:0] tx_q[$];
    logic [7:0] rx_last = '0, tx_last = '0;
    bit         m_en = 1'b0;
    logic [1:0] m_trig = 2'b00;

    always #2 clk = ~clk;

    uart_fifo_ctl u_uart_fifo_ctl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .rx_push(rx_push), .rx_pdata(rx_pdata), .rx_pop(rx_pop),
        .rx_rdata(rx_rdata), .rx_empty(rx_empty), .rx_full(rx_full),
        .rx_count(rx_count), .rx_irq(rx_irq),
        .tx_push(tx_push), .tx_pdata(tx_pdata), .tx_pop(tx_pop),
        .tx_rdata(tx_rdata), .tx_empty(tx_empty), .tx_full(tx_full)
    );

    function automatic int level_of(logic [1:0] t);
        case (t)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_state(string req);
        chk(req, "rx_count", int'(rx_count), rx_q.size());
        chk(req, "rx_empty", int'(rx_empty), int'(rx_q.size() == 0));
        chk(req, "rx_full",  int'(rx_full),  int'(rx_q.size() == 16));
        chk(req, "tx_empty", int'(tx_empty), int'(tx_q.size() == 0));
        chk(req, "tx_full",  int'(tx_full),  int'(tx_q.size() == 16));
        chk(req, "rx_irq",   int'(rx_irq),   int'(rx_q.size() >= level_of(m_trig)));
        chk(req, "rx_rdata", int'(rx_rdata), int'(rx_last));
        chk(req, "tx_rdata", int'(tx_rdata), int'(tx_last));
    endtask

    // driver: applies one cycle of stimulus and advances the scoreboard
    task automatic step(input bit we, input logic [7:0] wd,
                        input bit rp, input logic [7:0] rd, input bit rpo,
                        input bit tp, input logic [7:0] td, input bit tpo);
        bit fr, ft, en_old;
        int rs, ts;
        @(negedge clk);
        cfg_we = we; cfg_wdata = wd;
        rx_push = rp; rx_pdata = rd; rx_pop = rpo;
        tx_push = tp; tx_pdata = td; tx_pop = tpo;
        @(posedge clk);
        en_old = m_en;
        fr = we && ((wd[0] != m_en) || (wd[0] && wd[1]));
        ft = we && ((wd[0] != m_en) || (wd[0] && wd[2]));
        if (we) begin
            m_en = wd[0];
            if (wd[0]) m_trig = wd[7:6];
        end
        rs = rx_q.size(); ts = tx_q.size();
        if (fr) rx_q.delete();
        else if (en_old) begin
            if (rpo && rs > 0) rx_last = rx_q.pop_front();
            if (rp && rs < 16) rx_q.push_back(rd);
        end
        if (ft) tx_q.delete();
        else if (en_old) begin
            if (tpo && ts > 0) tx_last = tx_q.pop_front();
            if (tp && ts < 16) tx_q.push_back(td);
        end
        #1;
        cfg_we = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
    endtask

    task automatic wr(input logic [7:0] wd);
        step(1, wd, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic rxp(input logic [7:0] d);
        step(0, 0, 1, d, 0, 0, 0, 0);
    endtask
    task automatic rxo();
        step(0, 0, 0, 0, 1, 0, 0, 0);
    endtask
    task automatic txp(input logic [7:0] d);
        step(0, 0, 0, 0, 0, 1, d, 0);
    endtask
    task automatic txo();
        step(0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check_state("R1");
        chk("R1", "rx_count reset", int'(rx_count), 0);
        chk("R1", "rx_irq reset", int'(rx_irq), 0);

        // R2: disabled queues ignore traffic
        rxp(8'h11); txp(8'h22); check_state("R2");
        rxo(); check_state("R2");

        // R3: enable rising edge
        wr(8'h01); check_state("R3");

        // R11 / R8: short burst then drain in order
        rxp(8'hA1); rxp(8'hA2); rxp(8'hA3); check_state("R11");
        for (int i = 0; i < 3; i++) begin rxo(); check_state("R8"); end
        rxo(); check_state("R9");

        // R8: overfill transmit queue
        for (int i = 0; i < 17; i++) txp(8'(8'h40 + i));
        check_state("R8");
        step(0, 0, 0, 0, 0, 1, 8'hEE, 1); check_state("R8");
        for (int i = 0; i < 16; i++) begin txo(); check_state("R8"); end
        txo(); check_state("R9");

        // R6: all four thresholds walked across their boundary
        wr(8'h41);
        for (int i = 0; i < 5; i++) begin rxp(8'(i)); check_state("R6"); end
        rxo(); check_state("R6"); rxo(); check_state("R6");
        wr(8'h81);
        for (int i = 0; i < 6; i++) begin rxp(8'(8'h50 + i)); check_state("R6"); end
        rxo(); check_state("R6");
        wr(8'hC1);
        for (int i = 0; i < 8; i++) begin rxp(8'(8'h60 + i)); check_state("R6"); end
        rxo(); check_state("R6");
        wr(8'h01); check_state("R6");

        // R4: receive flush leaves transmit data
        txp(8'h71); txp(8'h72);
        wr(8'h03); check_state("R4");
        rxp(8'h81); wr(8'h01); check_state("R4");

        // R5: transmit flush leaves receive data
        wr(8'h05); check_state("R5");
        txp(8'h91); wr(8'h01); check_state("R5");

        // R7: reserved bits have no effect (threshold 4 here)
        wr(8'h79); check_state("R7");
        rxp(8'h82); rxp(8'h83); check_state("R7");
        rxp(8'h84); check_state("R7");

        // R10: flush against same-cycle push and pop
        step(1, 8'h03, 1, 8'hB0, 1, 0, 0, 0); check_state("R10");
        txp(8'hB1);
        step(1, 8'h05, 0, 0, 0, 1, 8'hB2, 1); check_state("R10");

        // R3: disable with data present, then traffic ignored
        rxp(8'hC0); txp(8'hC1); check_state("R3");
        wr(8'h00); check_state("R3");
        rxp(8'hC2); txp(8'hC3); check_state("R2");
        wr(8'h01); rxp(8'hC4); check_state("R3");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule